// File: doc/BRIEF.md
# Four-channel thermal trip supervisor

This block guards four line drivers against overheating. It takes a junction temperature as an unsigned 8-bit value in whole degrees Celsius and keeps three registered over-temperature flags. Each flag has its own pair of trip and release points. From these flags and from each channel's current-limit and driver-active inputs it keeps one enable bit per channel. A driver may be switched on only while its enable bit is high. The block also gives a one-bit status that reads 1 above the top threshold, and a permit that says whether new activation requests may be taken.

The flags act as nested alarms. The lowest flag only stops new activations. The middle flag disables channels that are current limiting and holds them off. The top flag drops every enable bit, and it latches the enable bits of the channels that were active at that moment. A latched channel is released one at a time by a switch-off command for that channel. After a middle-level trip, that channel stays blocked until the die has cooled far enough. How far depends on whether the power-on sequencer is in use.

Top module: `thermal_guard`

## Requirements
- R1: The low flag (`hot1_o`) sets one clock after the temperature reaches 110 or more. It clears one clock after the temperature is 100 or less. `accept_o` is the inverse of this flag.
- R2: The middle flag (`hot2_o`) sets at 130 or more and clears at 120 or less, with one clock of latency.
- R3: The top flag (`hot3_o`) sets at 160 or more and clears at 150 or less, with one clock of latency.
- R4: While the middle flag is set, a channel whose `ilim_i` bit is 1 has its enable bit (`tor_o`) forced low and latched. Channels that are not limiting keep their enable bits.
- R5: While the top flag is set, all four `tor_o` bits are 0. Channels whose `active_i` bit is 1 at that time are latched low. The others return high on their own once the top flag clears.
- R6: An `off_i` pulse on a channel clears only that channel's latch. A trip condition in the same cycle wins over the command.
- R7: A channel tripped by the middle level stays low after its latch is cleared. It stays low until the middle flag clears when `seq_en_i` is 0, or until the low flag clears when `seq_en_i` is 1.
- R8: `tstat_o` is 1 exactly when the temperature sampled on the previous clock was above 160. At exactly 160 it reads 0.
- R9: After reset all `tor_o` bits are 1, all flags and `tstat_o` are 0, and `accept_o` is 1. Any latched channels are released.
- R10: A temperature strictly between a flag's release point and its trip point leaves that flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_i | input | 8 | Junction temperature, unsigned degrees Celsius |
| seq_en_i | input | 1 | Power-on sequencer in use; sets the cool-down point of R7 |
| ilim_i | input | 4 | Per-channel current-limit flag |
| active_i | input | 4 | Per-channel driver-active flag |
| off_i | input | 4 | Per-channel switch-off command |
| hot1_o | output | 1 | Low over-temperature flag |
| hot2_o | output | 1 | Middle over-temperature flag |
| hot3_o | output | 1 | Top over-temperature flag |
| tor_o | output | 4 | Per-channel driver enable, 1 = may be on |
| tstat_o | output | 1 | Temperature above the top threshold |
| accept_o | output | 1 | New activation requests may be accepted |

## Verification
The hardest state to reach is a channel whose latch has been cleared but which is still held off by the cool-down rule of R7. To get there, the stimulus first trips the middle level with that channel limiting. It then gives the switch-off command while the temperature sits in the band between a release point and a trip point. The bench checks that `tor_o` stays low there, then steps the temperature down to the exact release point, once with the sequencer on and once with it off. The top-level trip is checked with a mix of active and idle channels. This shows that the idle channels recover on their own while the active ones need their own switch-off commands.

// File: rtl/thg_pkg.sv
package thg_pkg;
  localparam int NLVL = 3;
  typedef struct packed {
    logic [7:0] trip;
    logic [7:0] rel;
  } thr_t;
endpackage

// File: rtl/thg_hyst.sv
module thg_hyst #(
  parameter int TW   = 8,
  parameter int TRIP = 110,
  parameter int REL  = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] temp_i,
  output logic          flag_o
);
  localparam logic [TW-1:0] TRIP_V = TW'(TRIP);
  localparam logic [TW-1:0] REL_V  = TW'(REL);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                flag_q <= 1'b0;
    else if (temp_i >= TRIP_V) flag_q <= 1'b1;
    else if (temp_i <= REL_V)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  p_trip_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_i >= TRIP_V) |=> flag_o);
  p_trip_rel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_i <= REL_V) |=> !flag_o);
  p_band_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_i > REL_V && temp_i < TRIP_V) |=> (flag_o == $past(flag_o)));
endmodule

// File: rtl/thg_chan.sv
module thg_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic hot1_i,
  input  logic hot2_i,
  input  logic hot3_i,
  input  logic seq_en_i,
  input  logic ilim_i,
  input  logic act_i,
  input  logic off_i,
  output logic tor_o
);
  logic lat_q;   // latched low, needs a switch-off command
  logic wt_q;    // middle-level trip still waiting for cool-down
  logic set2, set3, cool;

  assign set2 = hot2_i & ilim_i;
  assign set3 = hot3_i & act_i;
  assign cool = seq_en_i ? ~hot1_i : ~hot2_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= 1'b0;
      wt_q  <= 1'b0;
    end else begin
      if (set2 | set3) lat_q <= 1'b1;
      else if (off_i)  lat_q <= 1'b0;
      if (set2)        wt_q <= 1'b1;
      else if (cool)   wt_q <= 1'b0;
    end
  end

  assign tor_o = ~lat_q & ~wt_q & ~hot3_i;

  p_lim_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hot2_i && ilim_i) |=> !tor_o);
  p_hot_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hot3_i && act_i) |=> !tor_o);
  p_off_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (off_i && !set2 && !set3) |=> !lat_q);
  p_cool_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_en_i && hot2_i && wt_q) |=> !tor_o);
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard #(
  parameter int NCH     = 4,
  parameter int TW      = 8,
  parameter int L1_TRIP = 110,
  parameter int L1_REL  = 100,
  parameter int L2_TRIP = 130,
  parameter int L2_REL  = 120,
  parameter int L3_TRIP = 160,
  parameter int L3_REL  = 150
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [TW-1:0]  temp_i,
  input  logic           seq_en_i,
  input  logic [NCH-1:0] ilim_i,
  input  logic [NCH-1:0] active_i,
  input  logic [NCH-1:0] off_i,
  output logic           hot1_o,
  output logic           hot2_o,
  output logic           hot3_o,
  output logic [NCH-1:0] tor_o,
  output logic           tstat_o,
  output logic           accept_o
);
  import thg_pkg::*;

  localparam int TRIPS [NLVL] = '{L1_TRIP, L2_TRIP, L3_TRIP};
  localparam int RELS  [NLVL] = '{L1_REL,  L2_REL,  L3_REL};
  localparam logic [TW-1:0] TOP_V = TW'(L3_TRIP);

  logic [NLVL-1:0] hot;
  logic            tstat_q;

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    thg_hyst #(.TW(TW), .TRIP(TRIPS[g]), .REL(RELS[g])) u_hyst (
      .clk(clk), .rst_n(rst_n), .temp_i(temp_i), .flag_o(hot[g])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    thg_chan u_ch (
      .clk(clk), .rst_n(rst_n),
      .hot1_i(hot[0]), .hot2_i(hot[1]), .hot3_i(hot[2]),
      .seq_en_i(seq_en_i), .ilim_i(ilim_i[c]), .act_i(active_i[c]),
      .off_i(off_i[c]), .tor_o(tor_o[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tstat_q <= 1'b0;
    else        tstat_q <= (temp_i > TOP_V);
  end

  assign hot1_o   = hot[0];
  assign hot2_o   = hot[1];
  assign hot3_o   = hot[2];
  assign tstat_o  = tstat_q;
  assign accept_o = ~hot[0];

  p_tstat_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_i > TOP_V) |=> tstat_o);
  p_tstat_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_i <= TOP_V) |=> !tstat_o);
  p_top_all_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hot3_o) |-> (tor_o == '0));
endmodule

// File: tb/sim_thermal_guard.sv
module sim_thermal_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] temp_i = 8'd25;
  logic       seq_en_i = 1'b0;
  logic [3:0] ilim_i = '0, active_i = '0, off_i = '0;
  logic       hot1_o, hot2_o, hot3_o, tstat_o, accept_o;
  logic [3:0] tor_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  thermal_guard u0 (
    .clk(clk), .rst_n(rst_n), .temp_i(temp_i), .seq_en_i(seq_en_i),
    .ilim_i(ilim_i), .active_i(active_i), .off_i(off_i),
    .hot1_o(hot1_o), .hot2_o(hot2_o), .hot3_o(hot3_o),
    .tor_o(tor_o), .tstat_o(tstat_o), .accept_o(accept_o)
  );

  // fields: req(4) temp(8) seq(1) ilim(4) act(4) off(4) | hot{3,2,1}(3) tor(4) ts(1) acc(1)
  localparam int NV = 20;
  localparam logic [33:0] VEC [NV] = '{
    {4'd9, 8'd25,  1'b0, 4'h0, 4'h0, 4'h0, 3'b000, 4'hF, 1'b0, 1'b1},  // R9 idle
    {4'd1, 8'd109, 1'b0, 4'h0, 4'h0, 4'h0, 3'b000, 4'hF, 1'b0, 1'b1},  // R1 just below
    {4'd1, 8'd110, 1'b0, 4'h0, 4'h0, 4'h0, 3'b001, 4'hF, 1'b0, 1'b0},  // R1 trip
    {4'd10,8'd101, 1'b0, 4'h0, 4'h0, 4'h0, 3'b001, 4'hF, 1'b0, 1'b0},  // R10 hold
    {4'd1, 8'd100, 1'b0, 4'h0, 4'h0, 4'h0, 3'b000, 4'hF, 1'b0, 1'b1},  // R1 release
    {4'd4, 8'd130, 1'b0, 4'h2, 4'h3, 4'h0, 3'b011, 4'hD, 1'b0, 1'b0},  // R4 ch1 latched
    {4'd2, 8'd125, 1'b0, 4'h0, 4'h3, 4'h0, 3'b011, 4'hD, 1'b0, 1'b0},  // R2 band hold
    {4'd7, 8'd125, 1'b0, 4'h0, 4'h0, 4'h2, 3'b011, 4'hD, 1'b0, 1'b0},  // R7 still waits
    {4'd7, 8'd120, 1'b0, 4'h0, 4'h0, 4'h0, 3'b001, 4'hF, 1'b0, 1'b0},  // R7 released at 120
    {4'd1, 8'd90,  1'b0, 4'h0, 4'h0, 4'h0, 3'b000, 4'hF, 1'b0, 1'b1},  // R1 cool
    {4'd4, 8'd135, 1'b1, 4'h1, 4'h1, 4'h0, 3'b011, 4'hE, 1'b0, 1'b0},  // R4 ch0, seq on
    {4'd7, 8'd115, 1'b1, 4'h0, 4'h0, 4'h1, 3'b001, 4'hE, 1'b0, 1'b0},  // R7 waits for 100
    {4'd7, 8'd100, 1'b1, 4'h0, 4'h0, 4'h0, 3'b000, 4'hF, 1'b0, 1'b1},  // R7 released at 100
    {4'd3, 8'd160, 1'b0, 4'h0, 4'h5, 4'h0, 3'b111, 4'h0, 1'b0, 1'b0},  // R3 R5 all low
    {4'd8, 8'd161, 1'b0, 4'h0, 4'h5, 4'h0, 3'b111, 4'h0, 1'b1, 1'b0},  // R8 above 160
    {4'd5, 8'd150, 1'b0, 4'h0, 4'h0, 4'h0, 3'b011, 4'hA, 1'b0, 1'b0},  // R5 idle recover
    {4'd6, 8'd150, 1'b0, 4'h0, 4'h0, 4'h1, 3'b011, 4'hB, 1'b0, 1'b0},  // R6 ch0 only
    {4'd6, 8'd60,  1'b0, 4'h0, 4'h0, 4'h4, 3'b000, 4'hF, 1'b0, 1'b1},  // R6 ch2
    {4'd6, 8'd140, 1'b0, 4'h8, 4'h8, 4'h8, 3'b011, 4'h7, 1'b0, 1'b0},  // R6 trip wins
    {4'd6, 8'd60,  1'b0, 4'h0, 4'h0, 4'h8, 3'b000, 4'hF, 1'b0, 1'b1}   // R6 clear ch3
  };

  task automatic check(input int req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual hot=%b tor=%b ts=%b acc=%b expected hot=%b tor=%b ts=%b acc=%b",
               req, act[8:6], act[5:2], act[1], act[0], exp[8:6], exp[5:2], exp[1], exp[0]);
    end
  endtask

  function automatic logic [8:0] observed();
    return {hot3_o, hot2_o, hot1_o, tor_o, tstat_o, accept_o};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(9, observed(), {3'b000, 4'hF, 1'b0, 1'b1});  // R9 during reset
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {temp_i, seq_en_i, ilim_i, active_i, off_i} = VEC[i][29:9];
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(int'(VEC[i][33:30]), observed(), VEC[i][8:0]);
    end
    // R9: reset releases latched channels
    temp_i = 8'd170; active_i = 4'hF; off_i = '0; ilim_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(8, observed(), {3'b111, 4'h0, 1'b1, 1'b0});  // R8 R5
    temp_i = 8'd25; active_i = '0;
    rst_n = 1'b0;
    @(negedge clk);
    check(9, observed(), {3'b000, 4'hF, 1'b0, 1'b1});  // R9 in reset
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(9, observed(), {3'b000, 4'hF, 1'b0, 1'b1});  // R9 after reset
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule